// File: doc/BRIEF.md
# Maintenance Bit Change Validation Filter

This block sits behind the frame aligner of a line transceiver. Each received line frame carries six maintenance bits. They arrive on `mbits` together with a one-clock `frame_stb`. The block splits them into two groups of three. The embedded-operations group is `mbits[2:0]` (M1..M3). The status group is `mbits[5:3]` (M4..M6). For each group it decides when a new value is trustworthy enough to pass to the system interface. Each accepted change is announced with a single report pulse. A message formatter downstream turns that pulse into a monitor message.

Three validation modes can be selected:

- **Three-in-a-row:** a value must repeat in consecutive frames.
- **Checksum-qualified:** the value of a superframe is held until the checksum verdict for that superframe arrives with the next superframe strobe.
- **Immediate:** any difference is accepted at once.

A second copy of the status-group filter feeds the activation state machine. By default it always uses the three-in-a-row rule. A configuration bit can make it follow the selected mode instead.

The configuration is captured only while the transceiver is deactivated, and deactivation also clears all filter state. The block also selects where the outgoing far-end block error bit comes from.

Top module: `mbit_validator`

## Requirements
- R1: `cfg_mode` selects the mode as follows: 2'b00 is three-in-a-row, 2'b01 is checksum-qualified, 2'b10 is immediate, and 2'b11 behaves as three-in-a-row. Bits `mbits[2:0]` form the operations group (`eoc_val`). Bits `mbits[5:3]` form the status group (`stat_val`, `ctl_val`).
- R2: In three-in-a-row mode, a group value different from the accepted one is accepted on the third consecutive `frame_stb` that carries it. Cycles without `frame_stb` neither advance nor break the sequence.
- R3: In three-in-a-row mode, a frame carrying a third value restarts the count at one for that new value. A frame carrying the accepted value abandons the candidate.
- R4: In checksum-qualified mode, the value of the last frame of a superframe is held as pending when `sf_stb` ends that superframe. It is accepted at the following `sf_stb` if `crc_ok` is high in that cycle. The value therefore appears one superframe late.
- R5: In checksum-qualified mode, a pending value whose `sf_stb` arrives with `crc_ok` low is discarded and never reported.
- R6: In immediate mode, a frame whose group value differs from the accepted one is accepted in the cycle after its `frame_stb`.
- R7: Every accepted change of a group raises that group's report output (`eoc_rpt` or `stat_rpt`) for exactly one clock. The pulse appears in the same cycle as the new value. A group's value never changes without its pulse, and a frame equal to the accepted value gives no pulse.
- R8: With `cfg_ctl_follow` = 0, `ctl_val` is filtered by the three-in-a-row rule whatever the mode. With `cfg_ctl_follow` = 1, it uses the selected mode.
- R9: Configuration inputs are captured while `deact` is high. The values present in the last deactivated cycle stay in force until `deact` is next raised, and changes at other times have no effect.
- R10: Reset, or any cycle with `deact` high, clears all accepted values, counters and pending data to zero and suppresses reports.
- R11: `fe_bit` equals `fe_int` when `cfg_fe_ext` = 0 and `fe_ext` when `cfg_fe_ext` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deact | input | 1 | Transceiver is in the deactivated state |
| cfg_mode | input | 2 | Validation mode select |
| cfg_ctl_follow | input | 1 | State-machine path follows selected mode |
| cfg_fe_ext | input | 1 | Far-end error bit from external value |
| frame_stb | input | 1 | New line frame on `mbits` |
| sf_stb | input | 1 | End of superframe |
| crc_ok | input | 1 | Checksum verdict, valid with `sf_stb` |
| mbits | input | 6 | Received maintenance bits M1..M6 (bit 0 = M1) |
| fe_int | input | 1 | Far-end error bit from internal counter logic |
| fe_ext | input | 1 | Far-end error bit written externally |
| eoc_val | output | 3 | Accepted operations-group value |
| eoc_rpt | output | 1 | Operations-group change report pulse |
| stat_val | output | 3 | Accepted status-group value |
| stat_rpt | output | 1 | Status-group change report pulse |
| ctl_val | output | 3 | Status bits validated for the state machine |
| fe_bit | output | 1 | Outgoing far-end error bit |

## Verification
The assertions check the following on every cycle:
- No report pulse appears without a change of value, and no value changes silently.
- The repeat counter stays inside its range.
- A checksum-qualified acceptance happens only on a superframe strobe with a good verdict.
- Deactivation leaves every group at zero.
- The captured configuration stays frozen while the transceiver is active.

Only the bench scenarios can show the rest:
- The exact frame count for three-in-a-row acceptance and how the count restarts when interrupted.
- The one-superframe delay, and discarding after a bad checksum.
- The state-machine path running ahead of the checksum-qualified status path.
- Configuration writes made while active being ignored.

// File: rtl/mbv_pkg.sv
package mbv_pkg;

  typedef enum logic [1:0] {
    MODE_TLL = 2'b00,
    MODE_CRC = 2'b01,
    MODE_CHG = 2'b10,
    MODE_RSV = 2'b11
  } filt_mode_e;

  // reserved code is folded onto the repeat filter
  function automatic filt_mode_e norm_mode(input logic [1:0] code);
    filt_mode_e m;
    case (code)
      2'b01:   m = MODE_CRC;
      2'b10:   m = MODE_CHG;
      default: m = MODE_TLL;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mbv_tll.sv
module mbv_tll #(
  parameter int W      = 3,
  parameter int REPEAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc,
  output logic         rpt
);
  localparam int CW = $clog2(REPEAT + 1);

  logic [W-1:0]  acc_q, acc_n;
  logic [W-1:0]  cand_q, cand_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          rpt_q, rpt_n;

  always_comb begin
    acc_n  = acc_q;
    cand_n = cand_q;
    cnt_n  = cnt_q;
    rpt_n  = 1'b0;
    if (clr) begin
      acc_n  = '0;
      cand_n = '0;
      cnt_n  = '0;
    end else if (stb) begin
      if (din == acc_q) begin
        cnt_n = '0;
      end else if (din == cand_q && cnt_q != '0) begin
        if (cnt_q == CW'(REPEAT - 1)) begin
          acc_n = din;
          cnt_n = '0;
          rpt_n = 1'b1;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end else begin
        cand_n = din;
        cnt_n  = CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
      rpt_q  <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      cand_q <= cand_n;
      cnt_q  <= cnt_n;
      rpt_q  <= rpt_n;
    end
  end

  assign acc = acc_q;
  assign rpt = rpt_q;

  // R2
  tll_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(REPEAT));

  // R2
  tll_rpt_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_q |-> $past(stb));

endmodule

// File: rtl/mbv_crc.sv
module mbv_crc #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stb,
  input  logic         sf_stb,
  input  logic         crc_ok,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc,
  output logic         rpt
);
  logic [W-1:0] last_q, last_n;
  logic         seen_q, seen_n;
  logic [W-1:0] pend_q, pend_n;
  logic         pvld_q, pvld_n;
  logic [W-1:0] acc_q, acc_n;
  logic         rpt_q, rpt_n;

  always_comb begin
    last_n = last_q;
    seen_n = seen_q;
    pend_n = pend_q;
    pvld_n = pvld_q;
    acc_n  = acc_q;
    rpt_n  = 1'b0;
    if (clr) begin
      last_n = '0;
      seen_n = 1'b0;
      pend_n = '0;
      pvld_n = 1'b0;
      acc_n  = '0;
    end else begin
      if (stb) begin
        last_n = din;
        seen_n = 1'b1;
      end
      if (sf_stb) begin
        pend_n = stb ? din : last_q;
        pvld_n = stb | seen_q;
        seen_n = 1'b0;
        if (pvld_q && crc_ok && pend_q != acc_q) begin
          acc_n = pend_q;
          rpt_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      seen_q <= 1'b0;
      pend_q <= '0;
      pvld_q <= 1'b0;
      acc_q  <= '0;
      rpt_q  <= 1'b0;
    end else begin
      last_q <= last_n;
      seen_q <= seen_n;
      pend_q <= pend_n;
      pvld_q <= pvld_n;
      acc_q  <= acc_n;
      rpt_q  <= rpt_n;
    end
  end

  assign acc = acc_q;
  assign rpt = rpt_q;

  // R4 R5
  crc_rpt_good_sf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_q |-> $past(sf_stb && crc_ok));

endmodule

// File: rtl/mbv_chg.sv
module mbv_chg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc,
  output logic         rpt
);
  logic [W-1:0] acc_q, acc_n;
  logic         rpt_q, rpt_n;

  always_comb begin
    acc_n = acc_q;
    rpt_n = 1'b0;
    if (clr) begin
      acc_n = '0;
    end else if (stb && din != acc_q) begin
      acc_n = din;
      rpt_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rpt_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      rpt_q <= rpt_n;
    end
  end

  assign acc = acc_q;
  assign rpt = rpt_q;

  // R6
  chg_rpt_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_q |-> $past(stb));

endmodule

// File: rtl/mbv_group.sv
module mbv_group
  import mbv_pkg::*;
#(
  parameter int W      = 3,
  parameter int REPEAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  filt_mode_e   mode,
  input  logic         stb,
  input  logic         sf_stb,
  input  logic         crc_ok,
  input  logic [W-1:0] din,
  output logic [W-1:0] val,
  output logic         rpt
);
  logic [W-1:0] tll_acc, crc_acc, chg_acc;
  logic         tll_rpt, crc_rpt, chg_rpt;

  mbv_tll #(.W(W), .REPEAT(REPEAT)) i_tll (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stb(stb), .din(din),
    .acc(tll_acc), .rpt(tll_rpt)
  );

  mbv_crc #(.W(W)) i_crc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stb(stb), .sf_stb(sf_stb),
    .crc_ok(crc_ok), .din(din), .acc(crc_acc), .rpt(crc_rpt)
  );

  mbv_chg #(.W(W)) i_chg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stb(stb), .din(din),
    .acc(chg_acc), .rpt(chg_rpt)
  );

  always_comb begin
    case (mode)
      MODE_CRC: begin val = crc_acc; rpt = crc_rpt; end
      MODE_CHG: begin val = chg_acc; rpt = chg_rpt; end
      default:  begin val = tll_acc; rpt = tll_rpt; end
    endcase
  end

  // R7
  grp_rpt_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt |-> val != $past(val));

  // R7
  grp_no_silent_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt && !$past(clr)) |-> $stable(val));

  // R10
  grp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (val == '0 && !rpt));

endmodule

// File: rtl/mbit_validator.sv
module mbit_validator
  import mbv_pkg::*;
#(
  parameter int GRP_W  = 3,
  parameter int REPEAT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               deact,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_ctl_follow,
  input  logic               cfg_fe_ext,
  input  logic               frame_stb,
  input  logic               sf_stb,
  input  logic               crc_ok,
  input  logic [2*GRP_W-1:0] mbits,
  input  logic               fe_int,
  input  logic               fe_ext,
  output logic [GRP_W-1:0]   eoc_val,
  output logic               eoc_rpt,
  output logic [GRP_W-1:0]   stat_val,
  output logic               stat_rpt,
  output logic [GRP_W-1:0]   ctl_val,
  output logic               fe_bit
);
  localparam int NGRP = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // configuration captured only while deactivated
  filt_mode_e mode_q, mode_n;
  logic       follow_q, follow_n;
  filt_mode_e ctl_mode;

  always_comb begin
    mode_n   = mode_q;
    follow_n = follow_q;
    if (deact) begin
      mode_n   = norm_mode(cfg_mode);
      follow_n = cfg_ctl_follow;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mode_q   <= MODE_TLL;
      follow_q <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      follow_q <= follow_n;
    end
  end

  assign ctl_mode = follow_q ? mode_q : MODE_TLL;

  // system-interface filters, one per bit group
  logic [GRP_W-1:0] grp_val [NGRP];
  logic             grp_rpt [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    mbv_group #(.W(GRP_W), .REPEAT(REPEAT)) i_grp (
      .clk(clk), .rst_n(rst_s), .clr(deact), .mode(mode_q),
      .stb(frame_stb), .sf_stb(sf_stb), .crc_ok(crc_ok),
      .din(mbits[g*GRP_W +: GRP_W]),
      .val(grp_val[g]), .rpt(grp_rpt[g])
    );
  end

  assign eoc_val  = grp_val[0];
  assign eoc_rpt  = grp_rpt[0];
  assign stat_val = grp_val[1];
  assign stat_rpt = grp_rpt[1];

  // state-machine path for the status group
  logic ctl_rpt_unused;

  mbv_group #(.W(GRP_W), .REPEAT(REPEAT)) i_ctl (
    .clk(clk), .rst_n(rst_s), .clr(deact), .mode(ctl_mode),
    .stb(frame_stb), .sf_stb(sf_stb), .crc_ok(crc_ok),
    .din(mbits[GRP_W +: GRP_W]),
    .val(ctl_val), .rpt(ctl_rpt_unused)
  );

  assign fe_bit = cfg_fe_ext ? fe_ext : fe_int;

  // R9
  cfg_frozen_active_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(deact) |-> ($stable(mode_q) && $stable(follow_q)));

  // R1
  cfg_mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mode_q != MODE_RSV);

endmodule

// File: tb/test_mbit_validator.sv
module test_mbit_validator;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       deact;
  logic [1:0] cfg_mode;
  logic       cfg_ctl_follow, cfg_fe_ext;
  logic       frame_stb, sf_stb, crc_ok;
  logic [5:0] mbits;
  logic       fe_int, fe_ext;
  logic [2:0] eoc_val, stat_val, ctl_val;
  logic       eoc_rpt, stat_rpt, fe_bit;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  mbit_validator i_mbit_validator (
    .clk(clk), .rst_n(rst_n), .deact(deact), .cfg_mode(cfg_mode),
    .cfg_ctl_follow(cfg_ctl_follow), .cfg_fe_ext(cfg_fe_ext),
    .frame_stb(frame_stb), .sf_stb(sf_stb), .crc_ok(crc_ok), .mbits(mbits),
    .fe_int(fe_int), .fe_ext(fe_ext), .eoc_val(eoc_val), .eoc_rpt(eoc_rpt),
    .stat_val(stat_val), .stat_rpt(stat_rpt), .ctl_val(ctl_val), .fe_bit(fe_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive after the edge, sample just after the next edge
  task automatic cyc(input logic fs, input logic ss, input logic ok, input logic [5:0] m);
    frame_stb = fs; sf_stb = ss; crc_ok = ok; mbits = m;
    @(posedge clk); #1;
    frame_stb = 1'b0; sf_stb = 1'b0; crc_ok = 1'b0;
  endtask

  task automatic enter_cfg(input logic [1:0] md, input logic fol);
    deact = 1'b1; cfg_mode = md; cfg_ctl_follow = fol;
    cyc(0, 0, 0, 6'b0);
    cyc(0, 0, 0, 6'b0);
    deact = 1'b0;
  endtask

  // {fs, ss, ok, mbits[5:0], exp eoc[2:0], eoc_rpt, exp stat[2:0], stat_rpt}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    {3'b100, 6'b000001, 3'b000, 1'b0, 3'b000, 1'b0},
    {3'b100, 6'b000001, 3'b000, 1'b0, 3'b000, 1'b0},
    {3'b100, 6'b000001, 3'b001, 1'b1, 3'b000, 1'b0},
    {3'b000, 6'b000001, 3'b001, 1'b0, 3'b000, 1'b0},
    {3'b100, 6'b101001, 3'b001, 1'b0, 3'b000, 1'b0},
    {3'b100, 6'b101001, 3'b001, 1'b0, 3'b000, 1'b0},
    {3'b100, 6'b110001, 3'b001, 1'b0, 3'b000, 1'b0},
    {3'b100, 6'b110001, 3'b001, 1'b0, 3'b000, 1'b0},
    {3'b100, 6'b110001, 3'b001, 1'b0, 3'b110, 1'b1},
    {3'b100, 6'b110010, 3'b001, 1'b0, 3'b110, 1'b0},
    {3'b100, 6'b110001, 3'b001, 1'b0, 3'b110, 1'b0},
    {3'b100, 6'b110010, 3'b001, 1'b0, 3'b110, 1'b0},
    {3'b100, 6'b110010, 3'b001, 1'b0, 3'b110, 1'b0},
    {3'b100, 6'b110010, 3'b010, 1'b1, 3'b110, 1'b0},
    {3'b100, 6'b000000, 3'b010, 1'b0, 3'b110, 1'b0},
    {3'b100, 6'b000000, 3'b010, 1'b0, 3'b110, 1'b0},
    {3'b100, 6'b000000, 3'b000, 1'b1, 3'b000, 1'b1}
  };

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; deact = 1'b0; cfg_mode = 2'b00; cfg_ctl_follow = 1'b0;
    cfg_fe_ext = 1'b0; frame_stb = 1'b0; sf_stb = 1'b0; crc_ok = 1'b0;
    mbits = '0; fe_int = 1'b0; fe_ext = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 reset eoc", eoc_val, 0);
    chk("R10 reset stat", stat_val, 0);
    chk("R10 reset ctl", ctl_val, 0);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 6'b0);

    // R2 R3 R7 three-in-a-row table
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:8]);
      chk($sformatf("R2/R3 vec%0d eoc_val", i), eoc_val, int'(VEC[i][7:5]));
      chk($sformatf("R7 vec%0d eoc_rpt", i), eoc_rpt, int'(VEC[i][4]));
      chk($sformatf("R2/R3 vec%0d stat_val", i), stat_val, int'(VEC[i][3:1]));
      chk($sformatf("R7 vec%0d stat_rpt", i), stat_rpt, int'(VEC[i][0]));
      chk($sformatf("R8 vec%0d ctl_val", i), ctl_val, int'(VEC[i][3:1]));
    end

    // R4 R5 R8 checksum-qualified, state-machine path on repeat filter
    enter_cfg(2'b01, 1'b0);
    chk("R10 deact clear stat", stat_val, 0);
    repeat (3) cyc(1, 0, 0, 6'b000011);
    chk("R4 not before strobe", eoc_val, 0);
    cyc(0, 1, 1, 6'b0);
    chk("R4 held one superframe", eoc_val, 0);
    chk("R4 no early report", eoc_rpt, 0);
    repeat (3) cyc(1, 0, 0, 6'b000011);
    cyc(0, 1, 1, 6'b0);
    chk("R4 accepted after superframe", eoc_val, 3);
    chk("R7 report with value", eoc_rpt, 1);
    cyc(0, 0, 0, 6'b0);
    chk("R7 single pulse", eoc_rpt, 0);
    repeat (3) cyc(1, 0, 0, 6'b100011);
    chk("R8 ctl path repeat filter", ctl_val, 4);
    chk("R4 stat still old", stat_val, 0);
    cyc(0, 1, 1, 6'b0);
    chk("R7 equal pending no report", eoc_rpt, 0);
    repeat (3) cyc(1, 0, 0, 6'b100011);
    cyc(0, 1, 0, 6'b0);
    chk("R5 bad checksum discards", stat_val, 0);
    chk("R5 no report", stat_rpt, 0);
    repeat (3) cyc(1, 0, 0, 6'b100011);
    cyc(0, 1, 1, 6'b0);
    chk("R4 next good superframe", stat_val, 4);
    chk("R4 report", stat_rpt, 1);

    // R6 R8 immediate mode, state-machine path following
    enter_cfg(2'b10, 1'b1);
    chk("R10 deact clear eoc", eoc_val, 0);
    chk("R10 deact clear ctl", ctl_val, 0);
    cyc(1, 0, 0, 6'b000101);
    chk("R6 immediate eoc", eoc_val, 5);
    chk("R6 immediate report", eoc_rpt, 1);
    cyc(1, 0, 0, 6'b111101);
    chk("R6 immediate stat", stat_val, 7);
    chk("R8 ctl follows mode", ctl_val, 7);
    chk("R7 other group quiet", eoc_rpt, 0);
    cyc(1, 0, 0, 6'b111101);
    chk("R7 same value no report", stat_rpt, 0);

    // R9 write while active is ignored
    cfg_mode = 2'b00; cfg_ctl_follow = 1'b0;
    cyc(1, 0, 0, 6'b111110);
    chk("R9 mode unchanged while active", eoc_val, 6);

    // R1 reserved code acts as three-in-a-row
    enter_cfg(2'b11, 1'b0);
    cyc(1, 0, 0, 6'b000111);
    cyc(1, 0, 0, 6'b000111);
    chk("R1 reserved not immediate", eoc_val, 0);
    cyc(1, 0, 0, 6'b000111);
    chk("R1 reserved third frame", eoc_val, 7);

    // R11 far-end error bit source
    cfg_fe_ext = 1'b0; fe_int = 1'b1; fe_ext = 1'b0; #1;
    chk("R11 internal source", fe_bit, 1);
    cfg_fe_ext = 1'b1; #1;
    chk("R11 external source 0", fe_bit, 0);
    fe_ext = 1'b1; fe_int = 1'b0; #1;
    chk("R11 external source 1", fe_bit, 1);

    // R10 reset mid-run
    rst_n = 1'b0; #1;
    chk("R10 async reset eoc", eoc_val, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule